// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Sequencer

This block moves outgoing packet data from memory into a transmit cell FIFO for one channel. The host writes the address of the first descriptor into the channel head pointer, and that write starts the engine. It then walks a linked chain of 16-byte descriptors. Each descriptor points to one buffer fragment. The engine reads each fragment word by word and packs the bytes into 64-byte cells. A cell is written downstream when it fills or when the packet ends. One packet may be split across several fragments, and a cell may hold bytes from more than one fragment.

Descriptor layout, as 32-bit words at byte offsets 0, 4, 8 and 12:
- Word 0 holds the link to the next descriptor. A value of zero ends the chain.
- Word 1 holds the buffer base address.
- Word 2 holds the offset in bits 31:16 and the byte length in bits 15:0.
- Word 3 holds the start-of-packet flag in bit 31, the end-of-packet flag in bit 30 and the ownership flag in bit 29. On the first descriptor of a packet, bits 15:0 also give the total packet length.

When the end-of-packet descriptor has been handled, the engine does three things in the same cycle. It writes word 3 back to memory with ownership cleared, loads the completion pointer with that descriptor's address, and pulses the interrupt.

The sequencer has nine states:
- WAIT: idle. It moves to FETCH on a nonzero head write.
- FETCH: reads the four descriptor words. It moves to INSPECT after the fourth word.
- INSPECT: goes to HALT on a bad descriptor, to FRAG_END if the length is zero, and to LOAD otherwise.
- LOAD: reads data words. It moves to PUSH when the cell fills or the packet's last byte arrives, and to FRAG_END when the fragment runs out.
- PUSH: waits for a free cell. After the write it goes to RETIRE if this was the last cell, to LOAD if fragment data remains, and to FRAG_END otherwise.
- FRAG_END: moves to PUSH (end of packet with bytes pending), to RETIRE (end of packet, nothing pending) or to STEP (more fragments follow).
- RETIRE: always moves to STEP.
- STEP: moves to WAIT on a zero link and to FETCH otherwise.
- HALT: moves to FETCH on a head write.

Top module: `txdma_chain_top`

## Requirements
- R1: After reset, no memory request, cell write, memory write or interrupt is active. The head pointer, completion pointer, cell byte count and error flag all read zero.
- R2: A host write with `hst_wr_sel`=0 and nonzero data, made while the engine is idle, loads the head pointer and starts the engine. The first four reads go to the head address +0, +4, +8 and +12, in that order.
- R3: After a valid descriptor, data is read from word 1 plus the offset in word 2 bits 31:16, on consecutive word addresses. Exactly the length in word 2 bits 15:0 is consumed, and only the low bytes of a final partial word are used.
- R4: Packet bytes fill cells in order. Byte k of a cell sits at `cell_data[8k+7:8k]`. Every cell that is not a packet's last carries `cell_bytes`=64 and `cell_eop`=0.
- R5: A packet's last cell carries `cell_eop`=1 and its true byte count, from 1 to 64, with unused bytes zero. Cells continue across fragment boundaries within a packet.
- R6: While `fifo_full` is 1, no cell is written, and the engine issues no further reads until the pending cell has gone out.
- R7: On an end-of-packet descriptor, the engine writes word 3 back to the descriptor address +12 with bit 29 cleared. In the same cycle it pulses `done_irq` for exactly one cycle, and the next cycle `cmpl_ptr` shows that descriptor's address.
- R8: A nonzero link fetches the next descriptor, even across packet boundaries. A zero link clears the head pointer and returns to idle.
- R9: A descriptor with bit 29 clear, or with bit 31 clear where a packet must start (the first descriptor, or the one after an end-of-packet descriptor), sets `err_flag`. The engine then makes no further reads or cell writes until a new head write, which clears the flag and restarts.
- R10: A head write while the engine is busy is ignored. The head pointer keeps its value.
- R11: A host write with `hst_wr_sel`=1 loads `cmpl_ptr` with the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr_en | input | 1 | Host pointer write strobe |
| hst_wr_sel | input | 1 | 0 selects head pointer, 1 selects completion pointer |
| hst_wr_data | input | 32 | Host write data |
| mem_rd_req | output | 1 | Read request, held until the response |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 32 | Read response data, lowest address in bits 7:0 |
| mem_wr_en | output | 1 | Descriptor write-back strobe |
| mem_wr_addr | output | 32 | Write-back address |
| mem_wr_data | output | 32 | Write-back data |
| cell_wr_en | output | 1 | Cell write strobe |
| cell_data | output | 512 | Cell payload |
| cell_bytes | output | 7 | Valid bytes in the cell |
| cell_eop | output | 1 | Cell ends a packet |
| fifo_full | input | 1 | Downstream has no free cell |
| done_irq | output | 1 | Packet completion pulse |
| err_flag | output | 1 | Channel halted on a bad descriptor |
| head_ptr | output | 32 | Head descriptor pointer |
| cmpl_ptr | output | 32 | Completion pointer |

## Verification
The assertions take several things about the inputs for granted:
- Each read response arrives only while a request is pending, and only once per request.
- Buffer start addresses (base plus offset) are word-aligned.
- Every fragment except a packet's last has a length that is a multiple of four, and the last fragment is non-empty.
- `fifo_full` only changes away from the clock edge.

The bench's memory model answers each request after a fixed delay with a single-cycle strobe. All descriptors it builds follow the alignment and length rules. It changes `fifo_full` just after the rising edge, either held high or in a repeating on/off pattern.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 16;
    localparam int DESC_WORDS = DESC_BYTES / WORD_BYTES;

    // Flag positions in descriptor word 3.
    localparam int F_SOP = 31;
    localparam int F_EOP = 30;
    localparam int F_OWN = 29;

    localparam logic SEL_HEAD = 1'b0;
    localparam logic SEL_CMPL = 1'b1;

    typedef enum logic [3:0] {
        S_WAIT,
        S_FETCH,
        S_INSPECT,
        S_LOAD,
        S_PUSH,
        S_FRAG_END,
        S_RETIRE,
        S_STEP,
        S_HALT
    } seq_state_t;

endpackage

// File: rtl/txdma_ptr_regs.sv
module txdma_ptr_regs
    import txdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_wr_en,
    input  logic        hst_wr_sel,
    input  logic [31:0] hst_wr_data,
    input  logic        accept_head,
    input  logic        head_clr,
    input  logic        cmpl_set,
    input  logic [31:0] cmpl_val,
    output logic        start,
    output logic [31:0] head_ptr,
    output logic [31:0] cmpl_ptr
);

    always_comb begin
        start = hst_wr_en && (hst_wr_sel == SEL_HEAD) && accept_head
                && (hst_wr_data != 32'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= 32'd0;
        end else if (start) begin
            head_ptr <= hst_wr_data;
        end else if (head_clr) begin
            head_ptr <= 32'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_ptr <= 32'd0;
        end else if (cmpl_set) begin
            cmpl_ptr <= cmpl_val;
        end else if (hst_wr_en && hst_wr_sel == SEL_CMPL) begin
            cmpl_ptr <= hst_wr_data;
        end
    end

    p_cmpl_host_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_wr_sel == SEL_CMPL && !cmpl_set)
        |=> cmpl_ptr == $past(hst_wr_data));

endmodule

// File: rtl/txdma_cell_pack.sv
module txdma_cell_pack #(
    parameter  int CELL_BYTES = 64,
    localparam int CNT_W      = $clog2(CELL_BYTES + 1),
    localparam int CELL_W     = CELL_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_en,
    input  logic [31:0]       put_word,
    input  logic [2:0]        put_nb,
    input  logic              clr,
    output logic [CELL_W-1:0] cell_data,
    output logic [CNT_W-1:0]  cell_cnt
);

    logic [CELL_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (put_en) begin
            for (int i = 0; i < 4; i++) begin
                if (i < int'(put_nb) && int'(cnt_q) + i < CELL_BYTES) begin
                    data_q[(int'(cnt_q) + i) * 8 +: 8] <= put_word[i * 8 +: 8];
                end
            end
            cnt_q <= cnt_q + CNT_W'(put_nb);
        end
    end

    assign cell_data = data_q;
    assign cell_cnt  = cnt_q;

    p_cnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_cnt <= CNT_W'(CELL_BYTES));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        put_en |-> (int'(cell_cnt) + int'(put_nb)) <= CELL_BYTES);

endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
    import txdma_pkg::*;
#(
    parameter  int CELL_BYTES = 64,
    localparam int CNT_W      = $clog2(CELL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      start_ptr,
    input  logic             fifo_full,
    output logic             mem_rd_req,
    output logic [31:0]      mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [31:0]      mem_rd_data,
    output logic             pk_put,
    output logic [2:0]       pk_nb,
    output logic             pk_clr,
    input  logic [CNT_W-1:0] pk_cnt,
    output logic             cell_wr_en,
    output logic             cell_eop,
    output logic             mem_wr_en,
    output logic [31:0]      mem_wr_addr,
    output logic [31:0]      mem_wr_data,
    output logic             accept_head,
    output logic             head_clr,
    output logic             cmpl_set,
    output logic [31:0]      cmpl_val,
    output logic             done_irq,
    output logic             err_flag
);

    seq_state_t state, nxt;

    logic [DESC_WORDS-1:0][31:0] desc_q;
    logic [1:0]       widx_q;
    logic [31:0]      cur_q;
    logic [31:0]      rd_addr_q;
    logic [15:0]      remain_q;
    logic             last_q;
    logic             expect_sop_q;
    logic             err_q;

    logic [31:0]      d_next, d_buf;
    logic [15:0]      d_off, d_len;
    logic             d_sop, d_eop, d_own, bad_desc;
    logic [2:0]       nb;
    logic [15:0]      rem_new;
    logic [CNT_W-1:0] cnt_new;
    logic             cell_done;

    always_comb begin
        d_next   = desc_q[0];
        d_buf    = desc_q[1];
        d_off    = desc_q[2][31:16];
        d_len    = desc_q[2][15:0];
        d_sop    = desc_q[3][F_SOP];
        d_eop    = desc_q[3][F_EOP];
        d_own    = desc_q[3][F_OWN];
        bad_desc = !d_own || (expect_sop_q && !d_sop);
        nb       = (remain_q >= 16'd4) ? 3'd4 : remain_q[2:0];
        rem_new  = remain_q - 16'(nb);
        cnt_new  = pk_cnt + CNT_W'(nb);
        cell_done = (cnt_new == CNT_W'(CELL_BYTES)) || (rem_new == 16'd0 && d_eop);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_WAIT:     if (start) nxt = S_FETCH;
            S_FETCH:    if (mem_rd_valid && widx_q == 2'(DESC_WORDS - 1)) nxt = S_INSPECT;
            S_INSPECT: begin
                if (bad_desc)              nxt = S_HALT;
                else if (d_len == 16'd0)   nxt = S_FRAG_END;
                else                       nxt = S_LOAD;
            end
            S_LOAD: begin
                if (mem_rd_valid) begin
                    if (cell_done)               nxt = S_PUSH;
                    else if (rem_new == 16'd0)   nxt = S_FRAG_END;
                end
            end
            S_PUSH: begin
                if (!fifo_full) begin
                    if (last_q)                  nxt = S_RETIRE;
                    else if (remain_q != 16'd0)  nxt = S_LOAD;
                    else                         nxt = S_FRAG_END;
                end
            end
            S_FRAG_END: begin
                if (!d_eop)                  nxt = S_STEP;
                else if (pk_cnt != '0)       nxt = S_PUSH;
                else                         nxt = S_RETIRE;
            end
            S_RETIRE:   nxt = S_STEP;
            S_STEP:     nxt = (d_next == 32'd0) ? S_WAIT : S_FETCH;
            S_HALT:     if (start) nxt = S_FETCH;
            default:    nxt = S_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_WAIT;
        else        state <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q       <= '0;
            widx_q       <= '0;
            cur_q        <= '0;
            rd_addr_q    <= '0;
            remain_q     <= '0;
            last_q       <= 1'b0;
            expect_sop_q <= 1'b1;
            err_q        <= 1'b0;
        end else begin
            unique case (state)
                S_WAIT, S_HALT: begin
                    if (start) begin
                        cur_q        <= start_ptr;
                        widx_q       <= '0;
                        expect_sop_q <= 1'b1;
                        err_q        <= 1'b0;
                    end
                end
                S_FETCH: begin
                    if (mem_rd_valid) begin
                        desc_q[widx_q] <= mem_rd_data;
                        widx_q         <= widx_q + 2'd1;
                    end
                end
                S_INSPECT: begin
                    err_q     <= bad_desc;
                    rd_addr_q <= d_buf + {16'd0, d_off};
                    remain_q  <= d_len;
                    last_q    <= 1'b0;
                end
                S_LOAD: begin
                    if (mem_rd_valid) begin
                        rd_addr_q <= rd_addr_q + 32'(WORD_BYTES);
                        remain_q  <= rem_new;
                        last_q    <= (rem_new == 16'd0) && d_eop;
                    end
                end
                S_FRAG_END: last_q <= d_eop;
                S_STEP: begin
                    cur_q        <= d_next;
                    widx_q       <= '0;
                    expect_sop_q <= d_eop;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd_req  = (state == S_FETCH) || (state == S_LOAD);
        mem_rd_addr = (state == S_FETCH) ? (cur_q + {28'd0, widx_q, 2'b00}) : rd_addr_q;
        pk_put      = (state == S_LOAD) && mem_rd_valid;
        pk_nb       = nb;
        cell_wr_en  = (state == S_PUSH) && !fifo_full;
        pk_clr      = cell_wr_en;
        cell_eop    = last_q;
        mem_wr_en   = (state == S_RETIRE);
        mem_wr_addr = cur_q + 32'(DESC_BYTES - WORD_BYTES);
        mem_wr_data = desc_q[3] & ~(32'd1 << F_OWN);
        done_irq    = (state == S_RETIRE);
        cmpl_set    = (state == S_RETIRE);
        cmpl_val    = cur_q;
        head_clr    = (state == S_STEP) && (d_next == 32'd0);
        accept_head = (state == S_WAIT) || (state == S_HALT);
        err_flag    = err_q;
    end

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    p_cell_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_wr_en && !cell_eop) |-> pk_cnt == CNT_W'(CELL_BYTES));

    p_cell_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cell_wr_en |-> pk_cnt != '0);

    p_stall_noread_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH && fifo_full) |=> !mem_rd_req);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    p_irq_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (mem_wr_en && !mem_wr_data[F_OWN]));

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!mem_rd_req && !cell_wr_en && !mem_wr_en));

endmodule

// File: rtl/txdma_chain_top.sv
module txdma_chain_top #(
    parameter  int CELL_BYTES = 64,
    localparam int CNT_W      = $clog2(CELL_BYTES + 1),
    localparam int CELL_W     = CELL_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr_en,
    input  logic              hst_wr_sel,
    input  logic [31:0]       hst_wr_data,
    output logic              mem_rd_req,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [31:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              cell_wr_en,
    output logic [CELL_W-1:0] cell_data,
    output logic [CNT_W-1:0]  cell_bytes,
    output logic              cell_eop,
    input  logic              fifo_full,
    output logic              done_irq,
    output logic              err_flag,
    output logic [31:0]       head_ptr,
    output logic [31:0]       cmpl_ptr
);

    logic        start, accept_head, head_clr, cmpl_set;
    logic [31:0] cmpl_val;
    logic        pk_put, pk_clr;
    logic [2:0]  pk_nb;

    txdma_ptr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .hst_wr_en   (hst_wr_en),
        .hst_wr_sel  (hst_wr_sel),
        .hst_wr_data (hst_wr_data),
        .accept_head (accept_head),
        .head_clr    (head_clr),
        .cmpl_set    (cmpl_set),
        .cmpl_val    (cmpl_val),
        .start       (start),
        .head_ptr    (head_ptr),
        .cmpl_ptr    (cmpl_ptr)
    );

    txdma_cell_pack #(.CELL_BYTES(CELL_BYTES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .put_en    (pk_put),
        .put_word  (mem_rd_data),
        .put_nb    (pk_nb),
        .clr       (pk_clr),
        .cell_data (cell_data),
        .cell_cnt  (cell_bytes)
    );

    txdma_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_ptr    (hst_wr_data),
        .fifo_full    (fifo_full),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .pk_put       (pk_put),
        .pk_nb        (pk_nb),
        .pk_clr       (pk_clr),
        .pk_cnt       (cell_bytes),
        .cell_wr_en   (cell_wr_en),
        .cell_eop     (cell_eop),
        .mem_wr_en    (mem_wr_en),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .accept_head  (accept_head),
        .head_clr     (head_clr),
        .cmpl_set     (cmpl_set),
        .cmpl_val     (cmpl_val),
        .done_irq     (done_irq),
        .err_flag     (err_flag)
    );

    p_head_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_wr_sel == 1'b0 && !accept_head && !head_clr)
        |=> $stable(head_ptr));

endmodule

// File: tb/txdma_chain_top_tb_top.sv
module txdma_chain_top_tb_top;

    localparam int CB = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hst_wr_en = 1'b0;
    logic         hst_wr_sel = 1'b0;
    logic [31:0]  hst_wr_data = 32'd0;
    logic         mem_rd_req;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_valid;
    logic [31:0]  mem_rd_data;
    logic         mem_wr_en;
    logic [31:0]  mem_wr_addr, mem_wr_data;
    logic         cell_wr_en;
    logic [CB*8-1:0] cell_data;
    logic [6:0]   cell_bytes;
    logic         cell_eop;
    logic         fifo_full;
    logic         done_irq, err_flag;
    logic [31:0]  head_ptr, cmpl_ptr;

    always #2 clk = ~clk;   // 250 MHz

    txdma_chain_top #(.CELL_BYTES(CB)) dut_i (.*);

    typedef struct packed {
        logic [CB*8-1:0] d;
        logic [6:0]      n;
        logic            e;
    } cell_t;

    cell_t       cell_q[$];
    logic [31:0] done_addr_q[$];
    logic [31:0] done_word_q[$];
    logic [7:0]  pkt_bytes[$];
    logic [31:0] rd_log[$];
    logic [31:0] mem [int unsigned];

    int total = 0;
    int bad   = 0;
    int rd_count = 0;
    int stall_viol = 0;
    bit hold_full = 1'b0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input logic [31:0] a);
        return 8'(a ^ (a >> 7) ^ 32'h5A);
    endfunction

    task automatic set_byte(input logic [31:0] a, input logic [7:0] b);
        logic [31:0] w;
        w = mem.exists(a >> 2) ? mem[a >> 2] : 32'd0;
        w[(a % 4) * 8 +: 8] = b;
        mem[a >> 2] = w;
    endtask

    task automatic put_desc(input logic [31:0] da, input logic [31:0] nx,
                            input logic [31:0] bp, input logic [15:0] off,
                            input logic [15:0] len, input bit sop, input bit eop,
                            input bit own, input logic [15:0] tot);
        mem[da >> 2]        = nx;
        mem[(da >> 2) + 1]  = bp;
        mem[(da >> 2) + 2]  = {off, len};
        mem[(da >> 2) + 3]  = {sop, eop, own, 13'd0, tot};
    endtask

    // Driver: build one fragment and queue the expected results.
    task automatic add_frag(input logic [31:0] da, input logic [31:0] nx,
                            input logic [31:0] bp, input logic [15:0] off,
                            input logic [15:0] len, input bit sop, input bit eop,
                            input logic [15:0] tot);
        put_desc(da, nx, bp, off, len, sop, eop, 1'b1, tot);
        for (int i = 0; i < int'(len); i++) begin
            logic [31:0] a;
            a = bp + 32'(off) + 32'(i);
            set_byte(a, bval(a));
            pkt_bytes.push_back(bval(a));
        end
        if (eop) begin
            int n;
            n = pkt_bytes.size();
            for (int c = 0; c < n; c += CB) begin
                cell_t ce;
                ce.d = '0;
                ce.n = 7'((n - c) >= CB ? CB : (n - c));
                ce.e = ((c + CB) >= n);
                for (int k = 0; k < int'(ce.n); k++) ce.d[k*8 +: 8] = pkt_bytes[c + k];
                cell_q.push_back(ce);
            end
            pkt_bytes.delete();
            done_addr_q.push_back(da);
            done_word_q.push_back({sop, eop, 1'b0, 13'd0, tot});
        end
    endtask

    task automatic host_wr(input bit sel, input logic [31:0] d);
        @(posedge clk); #1;
        hst_wr_en = 1'b1; hst_wr_sel = sel; hst_wr_data = d;
        @(posedge clk); #1;
        hst_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (head_ptr == 32'd0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // Memory model: fixed latency, one response per request.
    initial begin
        int lat;
        lat = 0;
        mem_rd_valid = 1'b0;
        mem_rd_data  = 32'd0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0;
                lat = 0;
            end else if (mem_rd_req) begin
                lat++;
                if (lat >= 2) begin
                    mem_rd_data  = mem.exists(mem_rd_addr >> 2) ? mem[mem_rd_addr >> 2] : 32'd0;
                    mem_rd_valid = 1'b1;
                    rd_log.push_back(mem_rd_addr);
                    rd_count++;
                end
            end
            if (mem_wr_en) mem[mem_wr_addr >> 2] = mem_wr_data;
        end
    end

    // Downstream FIFO fullness.
    initial begin
        int cyc;
        cyc = 0;
        fifo_full = 1'b0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            fifo_full = hold_full || (stall_mode && (cyc % 5) < 2);
        end
    end

    // Monitor / scoreboard.
    initial begin
        bit pend;
        bit prev_irq;
        logic [31:0] pend_addr;
        pend = 1'b0;
        prev_irq = 1'b0;
        pend_addr = 32'd0;
        forever begin
            @(negedge clk);
            if (pend) begin
                chk(cmpl_ptr == pend_addr, "R7", "cmpl_ptr after retire", 64'(cmpl_ptr), 64'(pend_addr));
                pend = 1'b0;
            end
            if (cell_wr_en) begin
                if (fifo_full) stall_viol++;
                if (cell_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected cell", 64'(cell_bytes), 64'd0);
                end else begin
                    cell_t ex;
                    int bi;
                    ex = cell_q.pop_front();
                    bi = 0;
                    for (int k = CB - 1; k >= 0; k--)
                        if (cell_data[k*8 +: 8] != ex.d[k*8 +: 8]) bi = k;
                    chk(cell_data == ex.d, "R4", "cell byte", 64'(cell_data[bi*8 +: 8]), 64'(ex.d[bi*8 +: 8]));
                    chk(cell_bytes == ex.n, "R5", "cell byte count", 64'(cell_bytes), 64'(ex.n));
                    chk(cell_eop == ex.e, "R5", "cell eop", 64'(cell_eop), 64'(ex.e));
                end
            end
            if (done_irq) begin
                chk(!prev_irq, "R7", "irq wider than one cycle", 64'(prev_irq), 64'd0);
                if (done_addr_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected completion", 64'(mem_wr_addr), 64'd0);
                end else begin
                    logic [31:0] ea, ew;
                    ea = done_addr_q.pop_front();
                    ew = done_word_q.pop_front();
                    chk(mem_wr_en && mem_wr_addr == ea + 32'd12, "R7", "write-back addr", 64'(mem_wr_addr), 64'(ea + 32'd12));
                    chk(mem_wr_data == ew, "R7", "write-back word", 64'(mem_wr_data), 64'(ew));
                    pend = 1'b1;
                    pend_addr = ea;
                end
            end
            prev_irq = done_irq;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int rc;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!mem_rd_req && !cell_wr_en && !mem_wr_en && !done_irq, "R1", "idle strobes", 64'({mem_rd_req, cell_wr_en, mem_wr_en, done_irq}), 64'd0);
        chk(head_ptr == 0 && cmpl_ptr == 0, "R1", "pointers", 64'({head_ptr, cmpl_ptr}), 64'd0);
        chk(!err_flag && cell_bytes == 0, "R1", "err/count", 64'({err_flag, cell_bytes}), 64'd0);

        // Single-fragment packet, 100 bytes: cells of 64 and 36 (R2 R3 R4 R5 R7 R8)
        add_frag(32'h1000, 32'h0, 32'h8000, 16'd8, 16'd100, 1'b1, 1'b1, 16'd100);
        rd_log.delete();
        host_wr(1'b0, 32'h1000);
        chk(head_ptr == 32'h1000, "R2", "head loaded", 64'(head_ptr), 64'h1000);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk(rd_log[i] == 32'h1000 + 32'(4 * i), "R2", "descriptor read order", 64'(rd_log[i]), 64'(32'h1000 + 32'(4 * i)));
        chk(rd_log[4] == 32'h8008, "R3", "first data addr", 64'(rd_log[4]), 64'h8008);
        chk(rd_log.size() == 4 + 25, "R3", "read count", 64'(rd_log.size()), 64'd29);
        chk(head_ptr == 0, "R8", "head cleared at chain end", 64'(head_ptr), 64'd0);
        chk(mem[(32'h1000 >> 2) + 3][29] == 1'b0, "R7", "ownership cleared", 64'(mem[(32'h1000 >> 2) + 3]), 64'd0);

        // Three fragments (40, 60, 30) with long stall then toggling (R5 R6 R10)
        add_frag(32'h1100, 32'h1140, 32'h9000, 16'd0, 16'd40, 1'b1, 1'b0, 16'd130);
        add_frag(32'h1140, 32'h1180, 32'h9100, 16'd4, 16'd60, 1'b0, 1'b0, 16'd0);
        add_frag(32'h1180, 32'h0,    32'h9200, 16'd0, 16'd30, 1'b0, 1'b1, 16'd0);
        hold_full = 1'b1;
        host_wr(1'b0, 32'h1100);
        repeat (150) @(negedge clk);
        rc = rd_count;
        host_wr(1'b0, 32'h7770_0000);
        chk(head_ptr == 32'h1100, "R10", "busy head write ignored", 64'(head_ptr), 64'h1100);
        repeat (10) @(negedge clk);
        chk(rd_count == rc, "R6", "no reads while stalled", 64'(rd_count), 64'(rc));
        chk(cell_q.size() == 3, "R6", "no cell while full", 64'(cell_q.size()), 64'd3);
        hold_full = 1'b0;
        stall_mode = 1'b1;
        wait_idle();
        stall_mode = 1'b0;
        chk(stall_viol == 0, "R6", "cell written while full", 64'(stall_viol), 64'd0);
        chk(cell_q.size() == 0 && done_addr_q.size() == 0, "R5", "all cells seen", 64'(cell_q.size()), 64'd0);

        // Chain of two packets: exactly 64 bytes, then 64+10 (R4 R5 R8)
        add_frag(32'h1200, 32'h1240, 32'hA000, 16'd0, 16'd64, 1'b1, 1'b1, 16'd64);
        add_frag(32'h1240, 32'h1280, 32'hA100, 16'd0, 16'd64, 1'b1, 1'b0, 16'd74);
        add_frag(32'h1280, 32'h0,    32'hA200, 16'd12, 16'd10, 1'b0, 1'b1, 16'd0);
        host_wr(1'b0, 32'h1200);
        wait_idle();
        chk(cell_q.size() == 0 && done_addr_q.size() == 0, "R8", "chain across packets", 64'(done_addr_q.size()), 64'd0);
        chk(cmpl_ptr == 32'h1280, "R7", "final completion pointer", 64'(cmpl_ptr), 64'h1280);

        // R11: host sets completion pointer
        host_wr(1'b1, 32'hABCD_0000);
        chk(cmpl_ptr == 32'hABCD_0000, "R11", "host cmpl write", 64'(cmpl_ptr), 64'hABCD_0000);

        // R9: ownership missing
        put_desc(32'h3000, 32'h0, 32'hB000, 16'd0, 16'd8, 1'b1, 1'b1, 1'b0, 16'd8);
        host_wr(1'b0, 32'h3000);
        repeat (40) @(negedge clk);
        chk(err_flag == 1'b1, "R9", "err on unowned", 64'(err_flag), 64'd1);
        rc = rd_count;
        repeat (20) @(negedge clk);
        chk(rd_count == rc && head_ptr == 32'h3000, "R9", "halted quiet", 64'(rd_count), 64'(rc));
        // R9: start-of-packet missing, restart from halt
        put_desc(32'h3100, 32'h0, 32'hB000, 16'd0, 16'd8, 1'b0, 1'b1, 1'b1, 16'd8);
        host_wr(1'b0, 32'h3100);
        chk(err_flag == 1'b0, "R9", "restart clears err", 64'(err_flag), 64'd0);
        repeat (40) @(negedge clk);
        chk(err_flag == 1'b1, "R9", "err on missing sop", 64'(err_flag), 64'd1);
        // Recovery with a good packet
        add_frag(32'h3200, 32'h0, 32'hC000, 16'd0, 16'd5, 1'b1, 1'b1, 16'd5);
        host_wr(1'b0, 32'h3200);
        wait_idle();
        chk(!err_flag && cell_q.size() == 0 && done_addr_q.size() == 0, "R9", "recovered", 64'(cell_q.size()), 64'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule